// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between a handful of processor input pins and the core. It samples each pin every clock, remembers the level it saw last, and acts only when a pin's level differs from that remembered value. Each pin has its own sensitivity: some are level-sensitive and active-high and drive a bit in a pending-interrupt mask directly; one is sensitive to falling edges and latches its pending bit; two are active-low control pins, one of which stops the core and one of which asks for a core reset. Any pin index beyond the defined six is tracked but never acted on.

The pending mask feeds one combined interrupt request that stays high while any bit of the mask is set. When the core takes a source it pulses a clear input that carries the index of the pending bit it has handled. The pins are assumed synchronous to the block clock. The level register comes out of reset as all ones, so that active-low pins that are idle high raise no false event when reset is released.

Top module: `intr_pin_conditioner`

## Requirements
- R1: While reset is asserted, and in the first cycle after release with the edge-sensitive and active-low pins held high, the pending mask, the interrupt request, the halt request and the reset request are all zero.
- R2: A pin held at the level it already had causes no action. If the core clears the external-interrupt bit while pin 0 stays high, the bit stays clear.
- R3: Pin 0 (external interrupt) and pin 1 (system-management interrupt) are active-high and level-sensitive. When either pin changes level, pending bit 0 or bit 1 takes the new level on the next clock edge.
- R4: Pin 2 (machine check) is sensitive to falling edges. A 1-to-0 change sets pending bit 2 on the next edge. A rising change does not affect the bit, and the bit stays set until the core clears it.
- R5: Pin 3 (checkstop) is active-low. A change to 0 sets the halt output on the next edge, and a change to 1 clears it.
- R6: Pin 4 (hard reset) is active-low. A change to 0 gives a reset-request pulse exactly one cycle long. Holding the pin low gives no further pulses.
- R7: Pin 5 (soft reset) is level-sensitive. When it changes level, pending bit 3 takes the new level on the next edge.
- R8: The interrupt request is high in exactly those cycles in which the pending mask is non-zero. It falls only when every pending bit is clear.
- R9: Pins with an index of 6 or more change no output, whatever their levels.
- R10: A clear pulse with index k (0 external, 1 system-management, 2 machine check, 3 soft reset) clears pending bit k on the next edge. A set caused by a pin event in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Pin levels, already synchronous to clk |
| clr_valid_i | input | 1 | Core has taken a pending source |
| clr_idx_i | input | 2 | Index of the pending bit to clear |
| pending_o | output | 4 | Pending-interrupt mask |
| irq_o | output | 1 | Combined interrupt request |
| halt_o | output | 1 | Stop-core request |
| hreset_req_o | output | 1 | One-cycle core-reset request |

## Verification
A stale or corrupted level bit shows up at the next edge: a falling-edge source then either latches without a real fall or misses one, or a held pin is acted on again as if it had changed. Each such fault appears on the pending mask, halt or reset-request output one cycle after the pin stimulus. A combined request that comes apart from the mask appears in the same cycle as the mask update. The bench compares every output against a model in every cycle, so any such divergence is caught within one clock.

// File: rtl/intr_pin_pkg.sv
package intr_pin_pkg;

    // Pin positions; the decode below depends on them.
    localparam int PIN_EXT   = 0;
    localparam int PIN_SMI   = 1;
    localparam int PIN_MCHK  = 2;
    localparam int PIN_CSTOP = 3;
    localparam int PIN_HRST  = 4;
    localparam int PIN_SRST  = 5;
    localparam int NUM_DEFINED_PINS = 6;

    // Pending-mask slots.
    localparam int PB_EXT  = 0;
    localparam int PB_SMI  = 1;
    localparam int PB_MCHK = 2;
    localparam int PB_SRST = 3;
    localparam int PEND_W  = 4;
    localparam int CLR_W   = $clog2(PEND_W);

    typedef enum logic [2:0] {
        SENSE_NONE,
        SENSE_LVL_HI,
        SENSE_FALL,
        SENSE_HALT_LO,
        SENSE_RST_LO
    } sense_e;

    typedef struct packed {
        logic changed;
        logic level;
    } pin_evt_t;

    typedef struct packed {
        logic [PEND_W-1:0] set;
        logic [PEND_W-1:0] clr;
        logic              halt_on;
        logic              halt_off;
        logic              rst_pulse;
    } pin_act_t;

    function automatic sense_e sense_of(input int idx);
        case (idx)
            PIN_EXT:   return SENSE_LVL_HI;
            PIN_SMI:   return SENSE_LVL_HI;
            PIN_MCHK:  return SENSE_FALL;
            PIN_CSTOP: return SENSE_HALT_LO;
            PIN_HRST:  return SENSE_RST_LO;
            PIN_SRST:  return SENSE_LVL_HI;
            default:   return SENSE_NONE;
        endcase
    endfunction

    function automatic int pend_slot(input int idx);
        case (idx)
            PIN_EXT:  return PB_EXT;
            PIN_SMI:  return PB_SMI;
            PIN_MCHK: return PB_MCHK;
            PIN_SRST: return PB_SRST;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/pin_change_detect.sv
module pin_change_detect
    import intr_pin_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PINS-1:0]           pins_i,
    output pin_evt_t [NUM_PINS-1:0]       evt_o,
    output logic [NUM_PINS-1:0]           lvl_o
);

    logic [NUM_PINS-1:0] lvl_q;

    // Record every pin's level, defined or not; all ones after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '1;
        end else begin
            lvl_q <= pins_i;
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_evt
        assign evt_o[g].changed = pins_i[g] ^ lvl_q[g];
        assign evt_o[g].level   = pins_i[g];
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/pin_action_decode.sv
module pin_action_decode
    import intr_pin_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  pin_evt_t [NUM_PINS-1:0] evt_i,
    output pin_act_t                act_o
);

    pin_act_t [NUM_PINS-1:0] part;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam sense_e KIND = sense_of(g);
        localparam int     SLOT = pend_slot(g);
        pin_act_t p;

        always_comb begin
            p = '0;
            case (KIND)
                SENSE_LVL_HI: begin
                    if (evt_i[g].changed) begin
                        p.set[SLOT] = evt_i[g].level;
                        p.clr[SLOT] = ~evt_i[g].level;
                    end
                end
                SENSE_FALL: begin
                    p.set[SLOT] = evt_i[g].changed & ~evt_i[g].level;
                end
                SENSE_HALT_LO: begin
                    p.halt_on  = evt_i[g].changed & ~evt_i[g].level;
                    p.halt_off = evt_i[g].changed &  evt_i[g].level;
                end
                SENSE_RST_LO: begin
                    p.rst_pulse = evt_i[g].changed & ~evt_i[g].level;
                end
                default: begin
                    p = '0;
                end
            endcase
        end

        assign part[g] = p;
    end

    always_comb begin
        act_o = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            act_o = act_o | part[i];
        end
    end

endmodule

// File: rtl/pending_mask_reg.sv
module pending_mask_reg #(
    parameter int WIDTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] pin_clr_i,
    input  logic             clr_valid_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    output logic [WIDTH-1:0] pend_o,
    output logic             irq_o
);

    logic [WIDTH-1:0] core_clr;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] pend_d;
    logic             irq_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_clr
        assign core_clr[b] = clr_valid_i && (clr_idx_i == IDX_W'(b));
    end

    // Sets take precedence over either kind of clear.
    assign pend_d = (pend_q & ~(pin_clr_i | core_clr)) | set_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= |pend_d;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/core_ctrl_reg.sv
module core_ctrl_reg (
    input  logic clk,
    input  logic rst,
    input  logic halt_on_i,
    input  logic halt_off_i,
    input  logic rst_pulse_i,
    output logic halt_o,
    output logic hreset_req_o
);

    logic halt_q;
    logic rreq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            rreq_q <= 1'b0;
        end else begin
            if (halt_on_i) begin
                halt_q <= 1'b1;
            end else if (halt_off_i) begin
                halt_q <= 1'b0;
            end
            rreq_q <= rst_pulse_i;
        end
    end

    assign halt_o       = halt_q;
    assign hreset_req_o = rreq_q;

endmodule

// File: rtl/intr_pin_conditioner.sv
module intr_pin_conditioner
    import intr_pin_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                clr_valid_i,
    input  logic [CLR_W-1:0]    clr_idx_i,
    output logic [PEND_W-1:0]   pending_o,
    output logic                irq_o,
    output logic                halt_o,
    output logic                hreset_req_o
);

    pin_evt_t [NUM_PINS-1:0] evt;
    logic [NUM_PINS-1:0]     lvl_q;
    pin_act_t                act;

    pin_change_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .evt_o  (evt),
        .lvl_o  (lvl_q)
    );

    pin_action_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .evt_i (evt),
        .act_o (act)
    );

    pending_mask_reg #(.WIDTH(PEND_W), .IDX_W(CLR_W)) u_pend (
        .clk         (clk),
        .rst         (rst),
        .set_i       (act.set),
        .pin_clr_i   (act.clr),
        .clr_valid_i (clr_valid_i),
        .clr_idx_i   (clr_idx_i),
        .pend_o      (pending_o),
        .irq_o       (irq_o)
    );

    core_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .halt_on_i    (act.halt_on),
        .halt_off_i   (act.halt_off),
        .rst_pulse_i  (act.rst_pulse),
        .halt_o       (halt_o),
        .hreset_req_o (hreset_req_o)
    );

endmodule

// File: rtl/intr_pin_conditioner_checker.sv
module intr_pin_conditioner_checker
    import intr_pin_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] pins_i,
    input logic [NUM_PINS-1:0] lvl_q,
    input logic                clr_valid_i,
    input logic [CLR_W-1:0]    clr_idx_i,
    input logic [PEND_W-1:0]   pending_o,
    input logic                irq_o,
    input logic                halt_o,
    input logic                hreset_req_o
);

    assert_irq_tracks_mask_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o == (pending_o != '0));

    assert_ext_rise_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (pins_i[PIN_EXT] && !lvl_q[PIN_EXT]) |=> pending_o[PB_EXT]);

    assert_mchk_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (pending_o[PB_MCHK] && !(clr_valid_i && clr_idx_i == CLR_W'(PB_MCHK)))
        |=> pending_o[PB_MCHK]);

    assert_mchk_no_set_high_R4: assert property (@(posedge clk) disable iff (rst)
        (!pending_o[PB_MCHK] && pins_i[PIN_MCHK]) |=> !pending_o[PB_MCHK]);

    assert_halt_on_low_R5: assert property (@(posedge clk) disable iff (rst)
        (!pins_i[PIN_CSTOP] && lvl_q[PIN_CSTOP]) |=> halt_o);

    assert_halt_off_high_R5: assert property (@(posedge clk) disable iff (rst)
        (pins_i[PIN_CSTOP] && !lvl_q[PIN_CSTOP]) |=> !halt_o);

    assert_reset_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        hreset_req_o |=> !hreset_req_o);

    assert_core_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_valid_i && clr_idx_i == CLR_W'(PB_MCHK)
         && !(lvl_q[PIN_MCHK] && !pins_i[PIN_MCHK])) |=> !pending_o[PB_MCHK]);

endmodule

bind intr_pin_conditioner intr_pin_conditioner_checker #(.NUM_PINS(NUM_PINS)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .pins_i       (pins_i),
    .lvl_q        (lvl_q),
    .clr_valid_i  (clr_valid_i),
    .clr_idx_i    (clr_idx_i),
    .pending_o    (pending_o),
    .irq_o        (irq_o),
    .halt_o       (halt_o),
    .hreset_req_o (hreset_req_o)
);

// File: tb/intr_pin_conditioner_bench.sv
module intr_pin_conditioner_bench;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = 8'b0001_1100;
    logic          clr_v = 1'b0;
    logic [1:0]    clr_i = 2'd0;
    logic [3:0]    pending;
    logic          irq;
    logic          halt;
    logic          hreq;

    int checks = 0;
    int fails  = 0;

    // Model state, derived from the requirements.
    logic [NP-1:0] m_lvl = '1;
    logic [3:0]    m_pend = '0;
    logic          m_halt = 1'b0;
    logic          m_rreq = 1'b0;

    always #10 clk = ~clk;

    intr_pin_conditioner #(.NUM_PINS(NP)) u_intr_pin_conditioner (
        .clk          (clk),
        .rst          (rst),
        .pins_i       (pins),
        .clr_valid_i  (clr_v),
        .clr_idx_i    (clr_i),
        .pending_o    (pending),
        .irq_o        (irq),
        .halt_o       (halt),
        .hreset_req_o (hreq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " pending"}, 32'(pending), 32'(m_pend));
        chk({tag, " irq R8"}, 32'(irq), 32'(m_pend != 4'd0));
        chk({tag, " halt"}, 32'(halt), 32'(m_halt));
        chk({tag, " hreset"}, 32'(hreq), 32'(m_rreq));
    endtask

    task automatic model_edge(input logic [NP-1:0] p, input logic cv, input logic [1:0] ci);
        logic [NP-1:0] ch;
        ch = p ^ m_lvl;
        if (cv) m_pend[ci] = 1'b0;
        if (ch[0]) m_pend[0] = p[0];
        if (ch[1]) m_pend[1] = p[1];
        if (ch[2] && !p[2]) m_pend[2] = 1'b1;
        if (ch[3]) m_halt = !p[3];
        m_rreq = ch[4] && !p[4];
        if (ch[5]) m_pend[3] = p[5];
        m_lvl = p;
    endtask

    task automatic step(input logic [NP-1:0] p, input logic cv, input logic [1:0] ci,
                        input string tag);
        pins  = p;
        clr_v = cv;
        clr_i = ci;
        @(posedge clk);
        #5;
        model_edge(p, cv, ci);
        clr_v = 1'b0;
        check_all(tag);
    endtask

    localparam logic [NP-1:0] IDLE = 8'b0001_1100;

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        check_all("R1 in reset");
        rst = 1'b0;
        step(IDLE, 1'b0, 2'd0, "R1 after release");

        // R3: external and system-management levels
        step(IDLE | 8'b0000_0001, 1'b0, 2'd0, "R3 ext high");
        chk("R3 ext bit", 32'(pending[0]), 32'd1);
        step(IDLE | 8'b0000_0011, 1'b0, 2'd0, "R3 smi high");
        step(IDLE | 8'b0000_0010, 1'b0, 2'd0, "R3 ext low");
        chk("R3 ext cleared", 32'(pending[0]), 32'd0);
        step(IDLE, 1'b0, 2'd0, "R3 R8 all low");
        chk("R8 irq low", 32'(irq), 32'd0);

        // R2: repeat level after core clear
        step(IDLE | 8'b0000_0001, 1'b0, 2'd0, "R2 ext high");
        step(IDLE | 8'b0000_0001, 1'b1, 2'd0, "R2 core clear");
        step(IDLE | 8'b0000_0001, 1'b0, 2'd0, "R2 hold high");
        chk("R2 no re-set", 32'(pending[0]), 32'd0);
        step(IDLE, 1'b0, 2'd0, "R2 release");

        // R4: falling edge, sticky, rising ignored
        step(IDLE & ~8'b0000_0100, 1'b0, 2'd0, "R4 fall");
        chk("R4 set", 32'(pending[2]), 32'd1);
        step(IDLE, 1'b0, 2'd0, "R4 rise ignored");
        chk("R4 still set", 32'(pending[2]), 32'd1);
        step(IDLE, 1'b1, 2'd2, "R10 clear mchk");
        chk("R10 mchk cleared", 32'(pending[2]), 32'd0);
        step(IDLE & ~8'b0000_0100, 1'b1, 2'd2, "R10 set beats clear");
        chk("R10 set wins", 32'(pending[2]), 32'd1);
        step(IDLE, 1'b1, 2'd2, "R10 clear");

        // R8: irq drops only when mask empty
        step(IDLE | 8'b0010_0001, 1'b0, 2'd0, "R7 R8 two sources");
        step(IDLE | 8'b0010_0000, 1'b0, 2'd0, "R8 one left");
        chk("R8 irq held", 32'(irq), 32'd1);
        step(IDLE, 1'b0, 2'd0, "R7 sreset low");
        chk("R7 bit3 clear", 32'(pending[3]), 32'd0);

        // R5: checkstop
        step(IDLE & ~8'b0000_1000, 1'b0, 2'd0, "R5 halt");
        chk("R5 halt on", 32'(halt), 32'd1);
        step(IDLE & ~8'b0000_1000, 1'b0, 2'd0, "R5 hold");
        step(IDLE, 1'b0, 2'd0, "R5 run");
        chk("R5 halt off", 32'(halt), 32'd0);

        // R6: hard reset pulse
        step(IDLE & ~8'b0001_0000, 1'b0, 2'd0, "R6 low");
        chk("R6 pulse", 32'(hreq), 32'd1);
        step(IDLE & ~8'b0001_0000, 1'b0, 2'd0, "R6 held low");
        chk("R6 single pulse", 32'(hreq), 32'd0);
        step(IDLE, 1'b0, 2'd0, "R6 release");

        // R9: spare pins
        step(IDLE | 8'b1100_0000, 1'b0, 2'd0, "R9 spares high");
        step(IDLE | 8'b0100_0000, 1'b0, 2'd0, "R9 spare toggle");
        step(IDLE, 1'b0, 2'd0, "R9 spares low");
        chk("R9 no effect", 32'({pending, irq, halt, hreq}), 32'd0);

        // Near-exhaustive sweep over pin patterns and clears
        for (int k = 0; k < 1024; k++) begin
            logic [9:0] kk;
            kk = 10'(k);
            step(8'(k * 29) ^ 8'(k >> 3), kk[0] ^ kk[3], kk[2:1],
                 "R2 R3 R4 R5 R6 R7 R9 R10 sweep");
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule